// File: doc/BRIEF.md
# Dual-Edge Carry-Save Time Counter

This block is a free-running time counter that advances on every edge of a single fast clock, rising and falling alike. It therefore counts at twice the clock frequency. Each storage bit is built from two ordinary flip-flops: one clocked on the rising edge and one on the falling edge. The bit's value is the XOR of the two. To write a bit on one edge, the flip-flop owned by that edge loads the new value XORed with its partner's output. The partner keeps its value.

The count is kept in carry-save form, not as a rippled binary number. Each bit position is a half-adder cell that holds one sum bit and one carry bit. A cell's carry is taken in by the next position on the following edge. Because of this, no carry chain longer than one cell must settle within a half-cycle. The counter value is `sum + 2*carry`, modulo 2^W. Turning the two vectors into a binary value is left to whatever consumes them. Several capture channels can sample the same pair of vectors as a shared timebase.

Top module: `pdecs_counter`

## Requirements
- R1: While `rst` is high across both a rising and a falling clock edge, every flip-flop is cleared, so `sum_o` and `carry_o` both read zero.
- R2: With `en` high at an edge, the value V = (`sum_o` + 2*`carry_o`) mod 2^W increases by exactly one at that edge, on rising and falling edges alike.
- R3: The value wraps from 2^W-1 to 0 on the next enabled edge.
- R4: With `en` low at an edge, neither flip-flop of any bit changes at that edge, so `sum_o` and `carry_o` hold.
- R5: Bit n of V toggles once every 2^n enabled edges, so its period is 2^(n+1) half-cycles of the clock.
- R6: Within a cell, the sum bit and the carry bit are never both 1, so (`sum_o` & `carry_o`) is always zero.
- R7: `en` is taken separately at each edge. If it is high only at rising edges, V advances by one per full clock cycle.
- R8: A carry leaving cell i is absorbed by cell i+1 at the next edge. Counting from zero, the first six edges give (sum, carry) = (1,0), (0,1), (3,0), (2,1), (1,2), (4,1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock; both of its edges advance the count |
| rst | input | 1 | Synchronous active-high clear, taken on each edge |
| en | input | 1 | Count enable, taken on each edge |
| sum_o | output | W | Saved sum bit of each cell, weight 2^i |
| carry_o | output | W | Carry bit of each cell, weight 2^(i+1) |

## Verification
If one flip-flop of an XOR pair holds a wrong value, the sum or carry vector is corrupted at once. The folded value then jumps by a power of two instead of by one, and the step-by-one check flags it on the very next half-cycle. A carry that is dropped or handed to the wrong cell also breaks the step-by-one rule. In the early counts it shows up as a mismatch against the known (sum, carry) sequence, and for low cells it appears within a few edges. A wrong enable or reset path is seen within one clock cycle: the counter moves while it should hold, or it fails to read zero.

// File: rtl/pdecs_pkg.sv
`timescale 1ns/1ps
package pdecs_pkg;

    // Default counter width
    localparam int unsigned CNT_W_DEF = 64;

    // Increment fed into the lowest cell on every enabled edge
    localparam logic CNT_INC = 1'b1;

    // One carry-save position: saved sum bit and outgoing carry bit
    typedef struct packed {
        logic sum;
        logic cry;
    } cs_pair_t;

    // Half-adder step: stored sum bit plus incoming carry
    function automatic cs_pair_t ha_step(input logic s, input logic cin);
        cs_pair_t r;
        r.sum = s ^ cin;
        r.cry = s & cin;
        return r;
    endfunction

endpackage

// File: rtl/dual_edge_bit.sv
`timescale 1ns/1ps
module dual_edge_bit (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic d,
    output logic q
);

    logic rise_q;
    logic fall_q;

    // Rising-edge half: load d ^ partner so that the XOR becomes d
    always_ff @(posedge clk) begin
        if (rst)
            rise_q <= 1'b0;
        else if (en)
            rise_q <= d ^ fall_q;
    end

    // Falling-edge half: same rule, partner is the rising flop
    always_ff @(negedge clk) begin
        if (rst)
            fall_q <= 1'b0;
        else if (en)
            fall_q <= d ^ rise_q;
    end

    assign q = rise_q ^ fall_q;

    AST_RISE_HOLD: assert property (@(posedge clk) disable iff (rst) !en |=> $stable(rise_q)); // R4
    AST_FALL_HOLD: assert property (@(negedge clk) disable iff (rst) !en |=> $stable(fall_q)); // R4

endmodule

// File: rtl/cs_cell.sv
`timescale 1ns/1ps
module cs_cell
    import pdecs_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic cin,
    output logic sum_q,
    output logic cry_q
);

    cs_pair_t nxt;

    assign nxt = ha_step(sum_q, cin);

    dual_edge_bit u_sum (
        .clk (clk),
        .rst (rst),
        .en  (en),
        .d   (nxt.sum),
        .q   (sum_q)
    );

    dual_edge_bit u_cry (
        .clk (clk),
        .rst (rst),
        .en  (en),
        .d   (nxt.cry),
        .q   (cry_q)
    );

    AST_CELL_EXCL_RISE: assert property (@(posedge clk) disable iff (rst) !(sum_q && cry_q)); // R6
    AST_CELL_EXCL_FALL: assert property (@(negedge clk) disable iff (rst) !(sum_q && cry_q)); // R6

endmodule

// File: rtl/pdecs_counter.sv
`timescale 1ns/1ps
module pdecs_counter
    import pdecs_pkg::*;
#(
    parameter int unsigned W = CNT_W_DEF
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    output logic [W-1:0] sum_o,
    output logic [W-1:0] carry_o
);

    localparam int unsigned LSB_CELL = 0;

    generate
        for (genvar i = 0; i < W; i++) begin : g_cell
            logic cin_i;
            if (i == LSB_CELL) begin : g_lsb
                assign cin_i = CNT_INC;
            end else begin : g_up
                assign cin_i = carry_o[i-1];
            end
            cs_cell u_cell (
                .clk   (clk),
                .rst   (rst),
                .en    (en),
                .cin   (cin_i),
                .sum_q (sum_o[i]),
                .cry_q (carry_o[i])
            );
        end
    endgenerate

    // Checker state: what reset and enable were at each edge
    logic         en_rise_q;
    logic         en_fall_q;
    logic         rst_fall_q;
    logic [W-1:0] val_w;
    logic [W-1:0] adv_w;

    always_ff @(posedge clk) en_rise_q <= en;

    always_ff @(negedge clk) begin
        en_fall_q  <= en;
        rst_fall_q <= rst;
    end

    assign val_w = sum_o + {carry_o[W-2:0], 1'b0};
    assign adv_w = W'(en_rise_q) + W'(en_fall_q);

    AST_RESET_ZERO: assert property (@(posedge clk) disable iff (rst) ($past(rst) && rst_fall_q) |-> (sum_o == '0 && carry_o == '0)); // R1
    AST_STEP_ONE: assert property (@(posedge clk) disable iff (rst) !rst |=> (rst_fall_q || val_w == $past(val_w) + adv_w)); // R2
    AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (rst) (!rst && en && val_w == '1) |=> (rst_fall_q || val_w == (en_fall_q ? W'(1) : '0))); // R3

endmodule

// File: tb/pdecs_counter_test.sv
`timescale 1ns/1ps
module pdecs_counter_test;

    localparam int unsigned NW = 6;
    localparam int unsigned NTAB = 6;
    // Expected {sum, carry} low bytes for the first six edges from zero (R8)
    localparam logic [15:0] VEC [NTAB] = '{16'h0100, 16'h0001, 16'h0300,
                                           16'h0201, 16'h0102, 16'h0401};

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic en  = 1'b1;
    logic [63:0]   s64, c64, v64;
    logic [NW-1:0] sn, cn, vn;
    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    pdecs_counter uut (.clk(clk), .rst(rst), .en(en), .sum_o(s64), .carry_o(c64));
    pdecs_counter #(.W(NW)) uut_w6 (.clk(clk), .rst(rst), .en(en), .sum_o(sn), .carry_o(cn));

    assign v64 = s64 + {c64[62:0], 1'b0};
    assign vn  = sn + {cn[NW-2:0], 1'b0};

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk or negedge clk);
        #1;
    endtask

    initial begin
        int k;
        logic prev3;
        logic [63:0] hs, hc;
        // Reset held over several edges (R1)
        repeat (6) tick();
        chk("R1 sum", s64, 64'd0);
        chk("R1 carry", c64, 64'd0);
        @(negedge clk);
        #1;
        rst = 1'b0;
        chk("R1 narrow", {58'd0, sn | cn}, 64'd0);
        // Table walk: carry-save pattern and value (R8, R2)
        k = 0;
        for (int i = 0; i < NTAB; i++) begin
            tick();
            k++;
            chk("R8 sum", s64, {56'd0, VEC[i][15:8]});
            chk("R8 carry", c64, {56'd0, VEC[i][7:0]});
            chk("R2 value", v64, 64'(k));
        end
        // Long run: step, wrap, toggle period, exclusivity (R2 R3 R5 R6)
        prev3 = vn[3];
        while (k < 200) begin
            tick();
            k++;
            chk("R2 step", v64, 64'(k));
            chk("R3 wrap", {58'd0, vn}, 64'(k % 64));
            chk("R5 toggle", {63'd0, vn[3] != prev3}, {63'd0, (k % 8) == 0});
            prev3 = vn[3];
            chk("R6 exclusive", s64 & c64, 64'd0);
        end
        // Enable low: hold (R4)
        en = 1'b0;
        hs = s64;
        hc = c64;
        repeat (4) tick();
        chk("R4 sum hold", s64, hs);
        chk("R4 carry hold", c64, hc);
        chk("R4 narrow hold", {58'd0, vn}, 64'd8);
        // Enable only at rising edges (R7)
        for (int i = 1; i <= 10; i++) begin
            en = 1'b1;
            tick();
            chk("R7 rise step", v64, 64'(200 + i));
            en = 1'b0;
            tick();
            chk("R7 fall hold", v64, 64'(200 + i));
        end
        chk("R7 narrow", {58'd0, vn}, 64'd18);
        // Reset mid-run (R1), then restart (R2)
        en  = 1'b1;
        rst = 1'b1;
        repeat (4) tick();
        chk("R1 mid sum", s64, 64'd0);
        chk("R1 mid carry", c64, 64'd0);
        rst = 1'b0;
        repeat (3) tick();
        chk("R2 restart", v64, 64'd3);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule